// File: doc/BRIEF.md
# Arithmetic Status Flag Unit

This block works out the processor status flags for one add, subtract or bitwise operation on 8, 16 or 32-bit operands and keeps them in a registered flag word. The word also holds three control bits: trap, interrupt enable and direction. An execution stage drives the operands, the carry-in, an operation code and a width code, then raises `op_valid`. On the next clock edge the masked result and the new flags appear at the registered outputs.

A separate command path sets or clears any single bit of the flag word. Software-visible operations such as set-carry or clear-direction use this path. The command path can run in the same cycle as an arithmetic update. When both hit the same bit, the command wins for that bit, and every other bit still takes its arithmetic value.

Top module: `status_flag_unit`

## Requirements
- R1: A synchronous active-high `rst` clears `result_q` and every bit of `flags_q` to 0.
- R2: The `width_sel` codes are 00 for 8 bits, 01 for 16 bits, and 10 or 11 for 32 bits. Operand bits above the selected width are ignored, and `result_q` reads 0 above that width.
- R3: Op code 00 is an add, giving a+b+carry_in modulo 2^w, and the carry flag is the carry out of bit w-1. Op code 01 is a subtract, giving a-b-carry_in modulo 2^w, and the carry flag is set when a borrow occurred.
- R4: After an add or subtract, the overflow flag is 1 exactly when the signed (two's complement, width w) result lies outside the representable range.
- R5: After an add or subtract, the auxiliary flag holds the carry (for an add) or the borrow (for a subtract) from bit 3 into bit 4.
- R6: After any operation, the zero flag is 1 when the masked result is 0, and the sign flag equals bit w-1 of the result.
- R7: After any operation, the parity flag is 1 when bits 7..0 of the result hold an even number of ones, and 0 otherwise.
- R8: Op code 10 (AND) and op code 11 (OR) update only the zero, sign and parity flags. Carry, overflow and auxiliary keep their values, and carry_in is ignored.
- R9: While `op_valid` is 0, `result_q` holds its value, and the status bits hold theirs unless a command targets them.
- R10: The flag word layout is bit 0 carry, 1 parity, 2 auxiliary, 3 zero, 4 sign, 5 overflow, 6 trap, 7 interrupt enable and 8 direction. A `bit_cmd` of 01 sets the bit chosen by `bit_sel`, 10 clears it, and 00 or 11 does nothing. A `bit_sel` value of 9 or more selects no bit.
- R11: Trap, interrupt enable and direction change only through a set or clear command, never through an operation.
- R12: A set or clear command in the same cycle as `op_valid` decides the value of its target bit. All other bits take the operation's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Load the result and the status flags on this edge |
| op_code | input | 2 | 00 add, 01 subtract, 10 AND, 11 OR |
| width_sel | input | 2 | 00 8-bit, 01 16-bit, 1x 32-bit |
| operand_a | input | 32 | First operand |
| operand_b | input | 32 | Second operand (the subtrahend) |
| carry_in | input | 1 | Carry or borrow into bit 0 for add and subtract |
| bit_cmd | input | 2 | 01 set, 10 clear, others no command |
| bit_sel | input | 4 | Index of the flag-word bit targeted by `bit_cmd` |
| result_q | output | 32 | Registered masked result |
| flags_q | output | 9 | Registered flag word |

## Verification
Two functions can act in the same cycle: an arithmetic flag update and a single-bit command. The bench provokes this with an 8-bit add that produces a carry while a clear-carry command is issued, then with a subtract paired with a set on the zero flag. In each case it checks that the command target carries the command's value and that the other status bits carry the arithmetic values from its own model. It also issues a control-bit command during an operation and confirms that the operation leaves the control bits alone.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
  localparam int FLAG_N     = 9;
  localparam int FLAG_SEL_W = $clog2(FLAG_N + 1);

  localparam int F_CF = 0;
  localparam int F_PF = 1;
  localparam int F_AF = 2;
  localparam int F_ZF = 3;
  localparam int F_SF = 4;
  localparam int F_OF = 5;
  localparam int F_TF = 6;
  localparam int F_IF = 7;
  localparam int F_DF = 8;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_AND = 2'b10,
    OP_OR  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_SET  = 2'b01,
    CMD_CLR  = 2'b10,
    CMD_RSV  = 2'b11
  } cmd_e;

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } stat_t;
endpackage

// File: rtl/sfu_width_mask.sv
module sfu_width_mask #(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        width_sel,
  output logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] top_bit
);
  localparam int LANES = 3;

  logic [DATA_W-1:0] lane_mask [LANES];
  logic [DATA_W-1:0] lane_top  [LANES];

  // lane i covers DATA_W / 2^(LANES-1-i) bits: quarter, half, full
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int LW = DATA_W >> (LANES - 1 - i);
    always_comb begin
      for (int b = 0; b < DATA_W; b++) begin
        lane_mask[i][b] = (b < LW);
        lane_top[i][b]  = (b == LW - 1);
      end
    end
  end

  always_comb begin
    unique case (width_sel)
      2'b00:   begin mask = lane_mask[0]; top_bit = lane_top[0]; end
      2'b01:   begin mask = lane_mask[1]; top_bit = lane_top[1]; end
      default: begin mask = lane_mask[2]; top_bit = lane_top[2]; end
    endcase
  end
endmodule

// File: rtl/sfu_arith.sv
module sfu_arith
  import sfu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  op_e               op,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] top_bit,
  output logic [DATA_W-1:0] result,
  output logic              is_arith,
  output stat_t             stat
);
  localparam int WIDE_W = DATA_W + 1;

  logic [WIDE_W-1:0] wide;
  logic [WIDE_W-1:0] carry_pos;
  logic              a_top, b_top, r_top;

  assign is_arith  = (op == OP_ADD) || (op == OP_SUB);
  assign carry_pos = {top_bit, 1'b0};

  always_comb begin
    unique case (op)
      OP_ADD:  wide = {1'b0, a} + {1'b0, b} + WIDE_W'(cin);
      OP_SUB:  wide = {1'b0, a} - {1'b0, b} - WIDE_W'(cin);
      OP_AND:  wide = {1'b0, a & b};
      default: wide = {1'b0, a | b};
    endcase
  end

  assign result = wide[DATA_W-1:0] & mask;
  assign a_top  = |(a & top_bit);
  assign b_top  = |(b & top_bit);
  assign r_top  = |(result & top_bit);

  always_comb begin
    stat.cf = is_arith & (|(wide & carry_pos));
    stat.af = is_arith & (a[4] ^ b[4] ^ result[4]);
    unique case (op)
      OP_ADD:  stat.of = (a_top == b_top) && (r_top != a_top);
      OP_SUB:  stat.of = (a_top != b_top) && (r_top != a_top);
      default: stat.of = 1'b0;
    endcase
    stat.zf = (result == '0);
    stat.sf = r_top;
    stat.pf = ~^result[7:0];
  end
endmodule

// File: rtl/sfu_flag_reg.sv
module sfu_flag_reg
  import sfu_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  upd,
  input  logic                  is_arith,
  input  stat_t                 stat,
  input  logic [1:0]            bit_cmd,
  input  logic [FLAG_SEL_W-1:0] bit_sel,
  output logic [FLAG_N-1:0]     flags_q
);
  logic [FLAG_N-1:0] base;
  logic [FLAG_N-1:0] nxt;

  always_comb begin
    base = flags_q;
    if (upd) begin
      base[F_ZF] = stat.zf;
      base[F_SF] = stat.sf;
      base[F_PF] = stat.pf;
      if (is_arith) begin
        base[F_CF] = stat.cf;
        base[F_AF] = stat.af;
        base[F_OF] = stat.of;
      end
    end
  end

  for (genvar i = 0; i < FLAG_N; i++) begin : g_bit
    logic hit;
    assign hit = (bit_sel == FLAG_SEL_W'(i));
    always_comb begin
      if (hit && (bit_cmd == CMD_SET))      nxt[i] = 1'b1;
      else if (hit && (bit_cmd == CMD_CLR)) nxt[i] = 1'b0;
      else                                  nxt[i] = base[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= nxt;
  end
endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
  import sfu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  op_valid,
  input  logic [1:0]            op_code,
  input  logic [1:0]            width_sel,
  input  logic [DATA_W-1:0]     operand_a,
  input  logic [DATA_W-1:0]     operand_b,
  input  logic                  carry_in,
  input  logic [1:0]            bit_cmd,
  input  logic [FLAG_SEL_W-1:0] bit_sel,
  output logic [DATA_W-1:0]     result_q,
  output logic [FLAG_N-1:0]     flags_q
);
  logic [DATA_W-1:0] mask, top_bit;
  logic [DATA_W-1:0] a_m, b_m, result;
  logic              is_arith;
  stat_t             stat;

  sfu_width_mask #(.DATA_W(DATA_W)) u_mask (
    .width_sel (width_sel),
    .mask      (mask),
    .top_bit   (top_bit)
  );

  assign a_m = operand_a & mask;
  assign b_m = operand_b & mask;

  sfu_arith #(.DATA_W(DATA_W)) u_arith (
    .a        (a_m),
    .b        (b_m),
    .cin      (carry_in),
    .op       (op_e'(op_code)),
    .mask     (mask),
    .top_bit  (top_bit),
    .result   (result),
    .is_arith (is_arith),
    .stat     (stat)
  );

  sfu_flag_reg u_flags (
    .clk      (clk),
    .rst      (rst),
    .upd      (op_valid),
    .is_arith (is_arith),
    .stat     (stat),
    .bit_cmd  (bit_cmd),
    .bit_sel  (bit_sel),
    .flags_q  (flags_q)
  );

  always_ff @(posedge clk) begin
    if (rst)           result_q <= '0;
    else if (op_valid) result_q <= result;
  end
endmodule

// File: rtl/sfu_checker.sv
module sfu_checker
  import sfu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  op_valid,
  input logic [1:0]            op_code,
  input logic [1:0]            bit_cmd,
  input logic [FLAG_SEL_W-1:0] bit_sel,
  input logic [DATA_W-1:0]     result_q,
  input logic [FLAG_N-1:0]     flags_q
);
  logic cmd_act, cmd_ctrl, cmd_zf, cmd_pf, cmd_stat;
  assign cmd_act  = (bit_cmd == CMD_SET || bit_cmd == CMD_CLR) && (bit_sel < FLAG_SEL_W'(FLAG_N));
  assign cmd_ctrl = cmd_act && (bit_sel >= FLAG_SEL_W'(F_TF));
  assign cmd_zf   = cmd_act && (bit_sel == FLAG_SEL_W'(F_ZF));
  assign cmd_pf   = cmd_act && (bit_sel == FLAG_SEL_W'(F_PF));
  assign cmd_stat = cmd_act && (bit_sel <  FLAG_SEL_W'(F_TF));

  assert_ctrl_only_cmd_R11: assert property (@(posedge clk) disable iff (rst)
    !cmd_ctrl |=> $stable(flags_q[F_DF:F_TF]));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!op_valid && !cmd_stat) |=> ($stable(flags_q[F_OF:F_CF]) && $stable(result_q)));

  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !cmd_zf) |=> (flags_q[F_ZF] == (result_q == '0)));

  assert_parity_R7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !cmd_pf) |=> (flags_q[F_PF] == ~^result_q[7:0]));

  assert_logic_keeps_R8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code[1] && !cmd_act) |=>
      ($stable(flags_q[F_CF]) && $stable(flags_q[F_AF]) && $stable(flags_q[F_OF])));

  assert_cmd_set_R10: assert property (@(posedge clk) disable iff (rst)
    (bit_cmd == CMD_SET && bit_sel < FLAG_SEL_W'(FLAG_N)) |=> flags_q[$past(bit_sel)]);

  assert_cmd_clr_R12: assert property (@(posedge clk) disable iff (rst)
    (bit_cmd == CMD_CLR && bit_sel < FLAG_SEL_W'(FLAG_N)) |=> !flags_q[$past(bit_sel)]);
endmodule

bind status_flag_unit sfu_checker #(.DATA_W(DATA_W)) u_sfu_checker (
  .clk      (clk),
  .rst      (rst),
  .op_valid (op_valid),
  .op_code  (op_code),
  .bit_cmd  (bit_cmd),
  .bit_sel  (bit_sel),
  .result_q (result_q),
  .flags_q  (flags_q)
);

// File: tb/status_flag_unit_test.sv
module status_flag_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [1:0]  op_code = 2'b00;
  logic [1:0]  width_sel = 2'b00;
  logic [31:0] operand_a = '0;
  logic [31:0] operand_b = '0;
  logic        carry_in = 1'b0;
  logic [1:0]  bit_cmd = 2'b00;
  logic [3:0]  bit_sel = '0;
  logic [31:0] result_q;
  logic [8:0]  flags_q;

  int n_run = 0;
  int n_fail = 0;

  logic [31:0] exp_res = '0;
  logic [8:0]  exp_flg = '0;

  always #2 clk = ~clk;

  status_flag_unit uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .width_sel(width_sel), .operand_a(operand_a), .operand_b(operand_b),
    .carry_in(carry_in), .bit_cmd(bit_cmd), .bit_sel(bit_sel),
    .result_q(result_q), .flags_q(flags_q)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // bench model built from the requirement text, in signed integer arithmetic
  task automatic model(input logic [1:0] op, input logic [1:0] ws, input logic [31:0] a,
                       input logic [31:0] b, input logic cin, input logic [1:0] cmd,
                       input logic [3:0] sel, input logic valid);
    int     w = (ws == 2'b00) ? 8 : (ws == 2'b01) ? 16 : 32;
    longint m = longint'(1) << w;
    longint am = longint'(a) & (m - 1);
    longint bm = longint'(b) & (m - 1);
    longint sa = (am >= m / 2) ? am - m : am;
    longint sb = (bm >= m / 2) ? bm - m : bm;
    longint ci = longint'(cin);
    longint full, sres, r;
    int ones = 0;
    if (valid) begin
      if (op == 2'b00) begin
        full = am + bm + ci;
        r = full % m;
        sres = sa + sb + ci;
        exp_flg[0] = (full >= m);
        exp_flg[2] = ((am % 16) + (bm % 16) + ci) >= 16;
        exp_flg[5] = (sres > m / 2 - 1) || (sres < -(m / 2));
      end else if (op == 2'b01) begin
        full = am - bm - ci;
        r = (full + m) % m;
        sres = sa - sb - ci;
        exp_flg[0] = (full < 0);
        exp_flg[2] = ((am % 16) - (bm % 16) - ci) < 0;
        exp_flg[5] = (sres > m / 2 - 1) || (sres < -(m / 2));
      end else if (op == 2'b10) begin
        r = am & bm;
      end else begin
        r = am | bm;
      end
      for (int k = 0; k < 8; k++) ones += int'((r >> k) & 1);
      exp_res = r[31:0];
      exp_flg[1] = (ones % 2 == 0);
      exp_flg[3] = (r == 0);
      exp_flg[4] = ((r >> (w - 1)) & 1) == 1;
    end
    if (sel < 9 && cmd == 2'b01) exp_flg[sel] = 1'b1;
    if (sel < 9 && cmd == 2'b10) exp_flg[sel] = 1'b0;
  endtask

  // drive at a falling edge, let one rising edge capture, return at the next falling edge
  task automatic apply(input logic valid, input logic [1:0] op, input logic [1:0] ws,
                       input logic [31:0] a, input logic [31:0] b, input logic cin,
                       input logic [1:0] cmd, input logic [3:0] sel);
    op_valid = valid; op_code = op; width_sel = ws; operand_a = a; operand_b = b;
    carry_in = cin; bit_cmd = cmd; bit_sel = sel;
    model(op, ws, a, b, cin, cmd, sel, valid);
    @(negedge clk);
    op_valid = 1'b0; bit_cmd = 2'b00; carry_in = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 result", result_q, 32'h0);
    check("R1 flags", {23'h0, flags_q}, 32'h0);
  endtask

  task automatic t_add;
    apply(1, 2'b00, 2'b00, 32'h7F, 32'h01, 0, 2'b00, 4'd0);
    check("R4 add 8b signed overflow result", result_q, exp_res);
    check("R4 R5 R6 R7 add 8b flags", {23'h0, flags_q}, {23'h0, exp_flg});
    apply(1, 2'b00, 2'b00, 32'hFF, 32'h01, 0, 2'b00, 4'd0);
    check("R3 add 8b carry flags", {23'h0, flags_q}, {23'h0, exp_flg});
    apply(1, 2'b00, 2'b10, 32'hFFFF_FFFF, 32'h0, 1, 2'b00, 4'd0);
    check("R3 add 32b carry-in result", result_q, exp_res);
    check("R3 add 32b carry-in flags", {23'h0, flags_q}, {23'h0, exp_flg});
  endtask

  task automatic t_sub;
    apply(1, 2'b01, 2'b01, 32'h0, 32'h1, 0, 2'b00, 4'd0);
    check("R3 sub 16b borrow result", result_q, exp_res);
    check("R3 R5 sub 16b borrow flags", {23'h0, flags_q}, {23'h0, exp_flg});
    apply(1, 2'b01, 2'b11, 32'h8000_0000, 32'h1, 0, 2'b00, 4'd0);
    check("R4 sub 32b overflow flags", {23'h0, flags_q}, {23'h0, exp_flg});
    apply(1, 2'b01, 2'b00, 32'h10, 32'h0F, 1, 2'b00, 4'd0);
    check("R5 sub 8b nibble borrow flags", {23'h0, flags_q}, {23'h0, exp_flg});
  endtask

  task automatic t_width;
    apply(1, 2'b00, 2'b00, 32'hABCD_1203, 32'h5555_FF05, 0, 2'b00, 4'd0);
    check("R2 8b upper operand bits ignored", result_q, exp_res);
    apply(1, 2'b00, 2'b01, 32'hFFFF_7FFF, 32'hFFFF_0001, 0, 2'b00, 4'd0);
    check("R2 16b result masked", result_q, exp_res);
    check("R2 R6 16b sign from bit 15", {23'h0, flags_q}, {23'h0, exp_flg});
  endtask

  task automatic t_logic;
    apply(1, 2'b00, 2'b00, 32'hFF, 32'h01, 0, 2'b00, 4'd0);
    apply(1, 2'b10, 2'b00, 32'hF0, 32'h0F, 1, 2'b00, 4'd0);
    check("R8 AND result", result_q, exp_res);
    check("R8 AND keeps carry aux overflow", {23'h0, flags_q}, {23'h0, exp_flg});
    apply(1, 2'b11, 2'b01, 32'h8001, 32'h0100, 0, 2'b00, 4'd0);
    check("R8 OR flags", {23'h0, flags_q}, {23'h0, exp_flg});
  endtask

  task automatic t_idle;
    apply(0, 2'b00, 2'b10, 32'h1234, 32'h1, 0, 2'b00, 4'd0);
    check("R9 idle result holds", result_q, exp_res);
    check("R9 idle flags hold", {23'h0, flags_q}, {23'h0, exp_flg});
  endtask

  task automatic t_cmds;
    apply(0, 2'b00, 2'b00, 0, 0, 0, 2'b01, 4'd6);
    apply(0, 2'b00, 2'b00, 0, 0, 0, 2'b01, 4'd8);
    apply(0, 2'b00, 2'b00, 0, 0, 0, 2'b01, 4'd0);
    check("R10 set trap direction carry", {23'h0, flags_q}, {23'h0, exp_flg});
    apply(0, 2'b00, 2'b00, 0, 0, 0, 2'b10, 4'd8);
    apply(0, 2'b00, 2'b00, 0, 0, 0, 2'b01, 4'd12);
    apply(0, 2'b00, 2'b00, 0, 0, 0, 2'b11, 4'd7);
    check("R10 clear, out-of-range and reserved", {23'h0, flags_q}, {23'h0, exp_flg});
    apply(1, 2'b01, 2'b00, 32'h0, 32'h0, 0, 2'b01, 4'd7);
    check("R11 op leaves control bits", {23'h0, flags_q}, {23'h0, exp_flg});
    apply(1, 2'b11, 2'b00, 32'h0, 32'h0, 0, 2'b00, 4'd0);
    check("R11 logic op leaves control bits", {23'h0, flags_q}, {23'h0, exp_flg});
  endtask

  task automatic t_overlap;
    apply(1, 2'b00, 2'b00, 32'hFF, 32'h02, 0, 2'b10, 4'd0);
    check("R12 clear carry wins over add", {23'h0, flags_q}, {23'h0, exp_flg});
    check("R12 result still written", result_q, exp_res);
    apply(1, 2'b01, 2'b00, 32'h05, 32'h03, 0, 2'b01, 4'd3);
    check("R12 set zero wins over sub", {23'h0, flags_q}, {23'h0, exp_flg});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_add();
    t_sub();
    t_width();
    t_logic();
    t_idle();
    t_cmds();
    t_overlap();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule